// File: doc/BRIEF.md
# Dual audio baud-rate clock generator

This block derives audio bit clocks from four reference clock inputs, called A, B, C and I. It holds two independent divider chains. Generator A is intended for rates in the 44.1 kHz family and generator B for the 48 kHz family. Each generator picks one reference as its source. Each divides that source by a prescale, which is a power of four times two, multiplied by an 8-bit count. A single control bit decides which generator drives the shared clock outputs. All shared outputs carry the same clock.

A per-port routing stage sits after the generators. It gives each serial audio port one of these clocks: a raw reference clock, the output of generator A, or the output of generator B. Software configures the block through a write-only register port.

The block runs on one fast system clock. Each reference input passes through a two-stage synchronizer. Its rising edges then serve as count enables. A generator loads new settings only when its half-period ends, so a reconfiguration never produces a short pulse.

Top module: `audclk_gen`

## Requirements
- R1: After reset, both divide registers hold 2 (total divide 6), the control state selects generator A on the shared outputs, both generators take reference A, and every port selects reference I. All outputs are low while reset is held.
- R2: Divide register A is at address 1 and divide register B is at address 2. Bits 9:8 hold a prescale code p, which gives a prescale of 2<<(2p): 2, 8, 32 or 128. Bits 7:0 hold N-1. The generator output has a period of prescale×N source periods and is high for exactly half of it.
- R3: The control register is at address 0. Generator A's source code is in bits 22:20 and generator B's is in bits 18:16. The codes are 0 for reference A, 1 for B, 2 for I and 4 for C.
- R4: A generator whose active source code is 3, 5, 6 or 7 stops and holds its output level. Writing a valid code afterwards restarts it.
- R5: When control bit 31 is 1, all shared outputs follow generator B. When it is 0, they follow generator A. All shared outputs are always equal.
- R6: A control write stores only bits 31, 22:20 and 18:16. Every other bit of the written word has no effect.
- R7: A new divide or source value does not cut the half-period in progress short. The next toggle comes at the old timing, and the half-periods after it use the new value.
- R8: Port selects sit at addresses 3 and up, four ports per word. Port n uses byte n mod 4 of word n/4. The codes are 0x00 for reference I, 0x01 for A, 0x02 for B, 0x03 for C, 0x10 for generator A and 0x20 for generator B.
- R9: Port 8 always carries the clock selected for port 7. Its own byte, byte 0 of the word at address 5, has no effect.
- R10: A port whose select code is not one of the defined values drives a constant low clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than every reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 4 | Reference clocks: bit 0 A, bit 1 B, bit 2 C, bit 3 I |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| clk_out | output | 4 | Shared outputs, all driven by the selected generator |
| port_clk | output | 10 | Per-port routed clocks |

## Verification
The hardest case to reach is a reconfiguration that lands in the middle of a half-period. The bench waits until it sees a toggle of the shared output, then writes a much larger divide on the very next cycle. It measures the interval to the next toggle, which must still use the old divide, and the interval after that, which must use the new one. A second difficult case is recovery from a stalled generator. An invalid source code can never reach a terminal count, so the bench checks that the output stays frozen and then that a valid code restarts the generator.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    localparam int NUM_REFS  = 4;
    localparam int CFG_W     = 32;
    localparam int SRC_W     = 3;
    localparam int SEL_W     = 8;
    localparam int DIV_RESET = 2;

    localparam logic [1:0] REF_A = 2'd0;
    localparam logic [1:0] REF_B = 2'd1;
    localparam logic [1:0] REF_C = 2'd2;
    localparam logic [1:0] REF_I = 2'd3;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_DIV_A = 1;
    localparam int ADDR_DIV_B = 2;
    localparam int ADDR_PSEL0 = 3;

    localparam int CTRL_OUT_BIT = 31;
    localparam int CTRL_SRCA_LO = 20;
    localparam int CTRL_SRCB_LO = 16;

    localparam logic [SEL_W-1:0] PSEL_I     = 8'h00;
    localparam logic [SEL_W-1:0] PSEL_A     = 8'h01;
    localparam logic [SEL_W-1:0] PSEL_B     = 8'h02;
    localparam logic [SEL_W-1:0] PSEL_C     = 8'h03;
    localparam logic [SEL_W-1:0] PSEL_GEN_A = 8'h10;
    localparam logic [SEL_W-1:0] PSEL_GEN_B = 8'h20;

    typedef struct packed {
        logic       valid;
        logic [1:0] idx;
    } src_dec_t;

    // sparse generator source code to reference index
    function automatic src_dec_t decode_src(input logic [SRC_W-1:0] code);
        src_dec_t r;
        r.valid = 1'b1;
        r.idx   = REF_A;
        case (code)
            3'd0:    r.idx = REF_A;
            3'd1:    r.idx = REF_B;
            3'd2:    r.idx = REF_I;
            3'd4:    r.idx = REF_C;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audclk_ref_sync.sv
module audclk_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_lvl,
    output logic ref_tick
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[SYNC_STAGES-2:0], ref_in};
        st_d.last = st_q.sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_lvl  = st_q.sh[SYNC_STAGES-1];
    assign ref_tick = st_q.sh[SYNC_STAGES-1] & ~st_q.last;

    // R2: one count enable per reference rising edge
    a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);

endmodule

// File: rtl/audclk_brg.sv
module audclk_brg
    import audclk_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_tick,
    input  logic [DIV_W-1:0]    div_cfg,
    input  logic [SRC_W-1:0]    src_cfg,
    output logic                gen_out
);

    localparam int PRE_W    = 2;
    localparam int CNT_BITS = DIV_W - PRE_W;
    localparam int HALF_W   = CNT_BITS + 1 + 2 * ((1 << PRE_W) - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SRC_W-1:0]  src;
        logic [HALF_W-1:0] cnt;
        logic              out;
    } brg_st_t;

    localparam brg_st_t BRG_RST = '{
        div: DIV_W'(DIV_RESET),
        src: '0,
        cnt: '0,
        out: 1'b0
    };

    brg_st_t           st_d, st_q;
    src_dec_t          dec;
    logic [HALF_W-1:0] n_val;
    logic [HALF_W-1:0] half;
    logic              tick;
    logic              term;

    assign dec   = decode_src(st_q.src);
    assign n_val = HALF_W'(st_q.div[CNT_BITS-1:0]) + 1'b1;
    // half period = N * 4^p source edges (total divide 2*4^p*N)
    assign half  = n_val << {st_q.div[DIV_W-1 -: PRE_W], 1'b0};
    assign tick  = dec.valid & ref_tick[dec.idx];
    assign term  = tick && (st_q.cnt == half - 1'b1);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = term ? '0 : st_q.cnt + 1'b1;
        end
        if (term) begin
            st_d.out = ~st_q.out;
        end
        // settings load at a toggle, or at once if stalled
        if (term || !dec.valid) begin
            st_d.div = div_cfg;
            st_d.src = src_cfg;
            if (!dec.valid) st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BRG_RST;
        else        st_q <= st_d;
    end

    assign gen_out = st_q.out;

    // R2: counter stays inside the active half period
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < half);

    // R7: active settings move only together with a toggle or out of a stall
    a_r7_load_at_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({st_q.div, st_q.src}) |-> (!$stable(st_q.out) || $past(!dec.valid)));

    // R4: an invalid active source freezes the output
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.valid |=> $stable(st_q.out));

endmodule

// File: rtl/audclk_port_sel.sv
module audclk_port_sel
    import audclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_REFS-1:0] ref_lvl,
    input  logic                gen_a,
    input  logic                gen_b,
    output logic                port_clk
);

    typedef struct packed {
        logic pclk;
    } psel_st_t;

    psel_st_t st_d, st_q;
    logic     code_ok;
    logic     mux_val;

    always_comb begin
        code_ok = 1'b1;
        mux_val = 1'b0;
        case (sel)
            PSEL_I:     mux_val = ref_lvl[REF_I];
            PSEL_A:     mux_val = ref_lvl[REF_A];
            PSEL_B:     mux_val = ref_lvl[REF_B];
            PSEL_C:     mux_val = ref_lvl[REF_C];
            PSEL_GEN_A: mux_val = gen_a;
            PSEL_GEN_B: mux_val = gen_b;
            default:    code_ok = 1'b0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.pclk = mux_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port_clk = st_q.pclk;

    // R10: undefined select code gives a low port clock
    a_r10_bad_code_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!code_ok) |-> !st_q.pclk);

endmodule

// File: rtl/audclk_cfg.sv
module audclk_cfg
    import audclk_pkg::*;
#(
    parameter int NUM_PORTS = 10,
    parameter int DIV_W     = 10,
    parameter int SEL_REGS  = 3,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CFG_W-1:0]           wr_data,
    output logic                       out_sel_b,
    output logic [SRC_W-1:0]           src_a,
    output logic [SRC_W-1:0]           src_b,
    output logic [DIV_W-1:0]           div_a,
    output logic [DIV_W-1:0]           div_b,
    output logic [NUM_PORTS*SEL_W-1:0] psel
);

    localparam int PSEL_BITS = NUM_PORTS * SEL_W;
    localparam int PAD_W     = SEL_REGS * CFG_W;

    typedef struct packed {
        logic                 sel_b;
        logic [SRC_W-1:0]     src_a;
        logic [SRC_W-1:0]     src_b;
        logic [DIV_W-1:0]     div_a;
        logic [DIV_W-1:0]     div_b;
        logic [PSEL_BITS-1:0] psel;
    } cfg_st_t;

    localparam cfg_st_t CFG_RST = '{
        sel_b: 1'b0,
        src_a: '0,
        src_b: '0,
        div_a: DIV_W'(DIV_RESET),
        div_b: DIV_W'(DIV_RESET),
        psel:  '0
    };

    cfg_st_t          st_d, st_q;
    logic [PAD_W-1:0] psel_pad;
    logic             ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

    always_comb begin
        st_d     = st_q;
        psel_pad = PAD_W'(st_q.psel);
        if (ctrl_wr) begin
            st_d.sel_b = wr_data[CTRL_OUT_BIT];
            st_d.src_a = wr_data[CTRL_SRCA_LO +: SRC_W];
            st_d.src_b = wr_data[CTRL_SRCB_LO +: SRC_W];
        end
        if (wr_en && (wr_addr == ADDR_W'(ADDR_DIV_A))) st_d.div_a = wr_data[DIV_W-1:0];
        if (wr_en && (wr_addr == ADDR_W'(ADDR_DIV_B))) st_d.div_b = wr_data[DIV_W-1:0];
        for (int r = 0; r < SEL_REGS; r++) begin
            if (wr_en && (wr_addr == ADDR_W'(ADDR_PSEL0 + r))) begin
                psel_pad[r*CFG_W +: CFG_W] = wr_data;
            end
        end
        st_d.psel = psel_pad[PSEL_BITS-1:0];
    end

    generate
        if (PAD_W > PSEL_BITS) begin : g_pad_tail
            logic unused_pad_tail;
            assign unused_pad_tail = ^psel_pad[PAD_W-1:PSEL_BITS];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_RST;
        else        st_q <= st_d;
    end

    assign out_sel_b = st_q.sel_b;
    assign src_a     = st_q.src_a;
    assign src_b     = st_q.src_b;
    assign div_a     = st_q.div_a;
    assign div_b     = st_q.div_b;
    assign psel      = st_q.psel;

    // R6: control fields change only through a control write
    a_r6_ctrl_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_wr) |-> $stable({st_q.sel_b, st_q.src_a, st_q.src_b}));

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int NUM_PORTS   = 10,
    parameter int NUM_CLKOUT  = 4,
    parameter int DIV_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int ALIAS_PORT  = 8,
    parameter int ALIAS_SRC   = 7,
    localparam int SEL_REGS   = (NUM_PORTS + 3) / 4,
    localparam int ADDR_W     = $clog2(ADDR_PSEL0 + SEL_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_REFS-1:0]   ref_clk,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CFG_W-1:0]      wr_data,
    output logic [NUM_CLKOUT-1:0] clk_out,
    output logic [NUM_PORTS-1:0]  port_clk
);

    logic [NUM_REFS-1:0]        ref_lvl;
    logic [NUM_REFS-1:0]        ref_tick;
    logic                       out_sel_b;
    logic [SRC_W-1:0]           src_a, src_b;
    logic [DIV_W-1:0]           div_a, div_b;
    logic [NUM_PORTS*SEL_W-1:0] psel;
    logic                       gen_a, gen_b;

    generate
        for (genvar i = 0; i < NUM_REFS; i++) begin : g_sync
            audclk_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .ref_in   (ref_clk[i]),
                .ref_lvl  (ref_lvl[i]),
                .ref_tick (ref_tick[i])
            );
        end
    endgenerate

    audclk_cfg #(
        .NUM_PORTS (NUM_PORTS),
        .DIV_W     (DIV_W),
        .SEL_REGS  (SEL_REGS),
        .ADDR_W    (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .out_sel_b (out_sel_b),
        .src_a     (src_a),
        .src_b     (src_b),
        .div_a     (div_a),
        .div_b     (div_b),
        .psel      (psel)
    );

    audclk_brg #(.DIV_W(DIV_W)) u_brg_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .div_cfg  (div_a),
        .src_cfg  (src_a),
        .gen_out  (gen_a)
    );

    audclk_brg #(.DIV_W(DIV_W)) u_brg_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .div_cfg  (div_b),
        .src_cfg  (src_b),
        .gen_out  (gen_b)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam int SRC_PORT = (p == ALIAS_PORT) ? ALIAS_SRC : p;
            audclk_port_sel u_psel (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel      (psel[SRC_PORT*SEL_W +: SEL_W]),
                .ref_lvl  (ref_lvl),
                .gen_a    (gen_a),
                .gen_b    (gen_b),
                .port_clk (port_clk[p])
            );
        end
        if (ALIAS_PORT < NUM_PORTS) begin : g_alias
            logic unused_alias_byte;
            assign unused_alias_byte = ^psel[ALIAS_PORT*SEL_W +: SEL_W];

            // R9: the aliased port mirrors its source port
            a_r9_alias_follows: assert property (@(posedge clk) disable iff (!rst_n)
                port_clk[ALIAS_PORT] == port_clk[ALIAS_SRC]);
        end
    endgenerate

    typedef struct packed {
        logic [NUM_CLKOUT-1:0] clkout;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.clkout = {NUM_CLKOUT{out_sel_b ? gen_b : gen_a}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out = st_q.clkout;

    // R5: every shared output carries the same level
    a_r5_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(clk_out) == 0) || ($countones(clk_out) == NUM_CLKOUT));

endmodule

// File: tb/audclk_gen_tb_top.sv
module audclk_gen_tb_top;
    import audclk_pkg::*;

    localparam int NP  = 10;
    localparam int NC  = 4;
    localparam int LIM = 8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_clk = 4'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [NC-1:0] clk_out;
    logic [NP-1:0] port_clk;

    always #2 clk = ~clk;

    // reference periods in system cycles: A 4, B 6, C 10, I 8
    initial begin #1; forever #8  ref_clk[0] = ~ref_clk[0]; end
    initial begin #1; forever #12 ref_clk[1] = ~ref_clk[1]; end
    initial begin #1; forever #20 ref_clk[2] = ~ref_clk[2]; end
    initial begin #1; forever #16 ref_clk[3] = ~ref_clk[3]; end

    audclk_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clk_out  (clk_out),
        .port_clk (port_clk)
    );

    wire [NC+NP-1:0] obs = {port_clk, clk_out};

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        int    kind;
        int    idx;
        int    per;
        int    hi;
        string tag;
    } item_t;

    item_t q[$];
    bit    mon_busy = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic push_wait(input item_t it);
        q.push_back(it);
        @(negedge clk);
        wait (q.size() == 0 && !mon_busy);
    endtask

    task automatic exp_period(input int idx, input int per, input int hi, input string tag);
        item_t it;
        it.kind = 0; it.idx = idx; it.per = per; it.hi = hi; it.tag = tag;
        push_wait(it);
    endtask

    task automatic exp_low(input int idx, input string tag);
        item_t it;
        it.kind = 1; it.idx = idx; it.per = 0; it.hi = 0; it.tag = tag;
        push_wait(it);
    endtask

    task automatic exp_stable(input int idx, input string tag);
        item_t it;
        it.kind = 2; it.idx = idx; it.per = 0; it.hi = 0; it.tag = tag;
        push_wait(it);
    endtask

    task automatic wait_rise(input int idx, output bit ok);
        bit prev;
        prev = obs[idx];
        ok = 0;
        for (int i = 0; i < LIM; i++) begin
            @(negedge clk);
            if (!prev && obs[idx]) begin
                ok = 1;
                break;
            end
            prev = obs[idx];
        end
    endtask

    task automatic measure(input int idx, output int per, output int hi, output bit ok);
        bit prev;
        int cnt;
        per = -1;
        hi  = -1;
        wait_rise(idx, ok);
        if (ok) wait_rise(idx, ok);
        if (ok) begin
            ok   = 0;
            cnt  = 0;
            prev = 1'b1;
            for (int i = 0; i < LIM; i++) begin
                @(negedge clk);
                cnt++;
                if (prev && !obs[idx]) hi = cnt;
                if (!prev && obs[idx]) begin
                    per = cnt;
                    ok  = 1;
                    break;
                end
                prev = obs[idx];
            end
        end
    endtask

    // monitor: pops expected items and compares against the outputs
    initial begin
        item_t it;
        int per, hi, highs, changes;
        bit ok, v;
        forever begin
            wait (q.size() != 0);
            mon_busy = 1;
            it = q.pop_front();
            case (it.kind)
                0: begin
                    measure(it.idx, per, hi, ok);
                    check(ok && per == it.per, {it.tag, " period"}, per, it.per);
                    if (it.hi >= 0) check(ok && hi == it.hi, {it.tag, " high time"}, hi, it.hi);
                end
                1: begin
                    repeat (10) @(negedge clk);
                    highs = 0;
                    repeat (300) begin
                        @(negedge clk);
                        if (obs[it.idx]) highs++;
                    end
                    check(highs == 0, {it.tag, " high samples"}, highs, 0);
                end
                default: begin
                    repeat (10) @(negedge clk);
                    v = obs[it.idx];
                    changes = 0;
                    repeat (300) begin
                        @(negedge clk);
                        if (obs[it.idx] != v) changes++;
                        v = obs[it.idx];
                    end
                    check(changes == 0, {it.tag, " changes"}, changes, 0);
                end
            endcase
            mon_busy = 0;
        end
    end

    // R7: a write landing mid half-period keeps the old timing for that half
    task automatic reconfig_timing;
        bit p;
        int t1, t2;
        bit seen;
        p = clk_out[0];
        seen = 0;
        for (int i = 0; i < LIM; i++) begin
            @(negedge clk);
            if (clk_out[0] != p) begin seen = 1; break; end
        end
        check(seen, "R7 initial toggle found", 0, 1);
        p = clk_out[0];
        wr_en   = 1'b1;
        wr_addr = 3'(ADDR_DIV_A);
        wr_data = 32'h0000_010F;
        t1 = -1;
        for (int i = 1; i < LIM; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (clk_out[0] != p) begin t1 = i; break; end
        end
        check(t1 == 12, "R7 half period in flight uses old divide", t1, 12);
        p = clk_out[0];
        t2 = -1;
        for (int i = 1; i < LIM; i++) begin
            @(negedge clk);
            if (clk_out[0] != p) begin t2 = i; break; end
        end
        check(t2 == 256, "R7 following half period uses new divide", t2, 256);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(clk_out == '0, "R1 shared outputs low in reset", int'(clk_out), 0);
        check(port_clk == '0, "R1 port clocks low in reset", int'(port_clk), 0);
        rst_n = 1'b1;

        exp_period(0, 24, 12, "R1 default generator A divide 6 on ref A");
        exp_period(4, 8, 4, "R1 port0 default ref I");
        exp_period(13, 8, 4, "R1 port9 default ref I");

        wr(ADDR_DIV_A, 32'h0000_0101);
        exp_period(0, 64, 32, "R2 prescale 8 count 2");
        exp_period(3, 64, 32, "R5 clk_out3 same rate");
        wr(ADDR_DIV_A, 32'h0000_0300);
        exp_period(0, 512, 256, "R2 prescale 128 count 1");
        wr(ADDR_DIV_A, 32'h0000_00FF);
        exp_period(0, 2048, 1024, "R2 prescale 2 count 256");
        wr(ADDR_DIV_A, 32'h0000_0002);

        wr(ADDR_CTRL, 32'h8001_0000);
        exp_period(1, 36, 18, "R3 R5 generator B on ref B");
        wr(ADDR_CTRL, 32'h8004_0000);
        exp_period(1, 60, 30, "R3 generator B code 4 ref C");
        wr(ADDR_CTRL, 32'h8002_0000);
        exp_period(2, 48, 24, "R3 generator B code 2 ref I");
        wr(ADDR_CTRL, 32'h0040_0000);
        exp_period(0, 60, 30, "R3 generator A code 4 ref C");
        wr(ADDR_CTRL, 32'h0020_0000);
        exp_period(0, 48, 24, "R3 R5 generator A code 2 ref I");

        wr(ADDR_CTRL, 32'hFF89_FFFF);
        wr(ADDR_PSEL0, 32'h0000_1000);
        exp_period(2, 36, 18, "R6 masked control picks generator B ref B");
        exp_period(5, 24, 12, "R6 generator A back on ref A");

        wr(ADDR_DIV_B, 32'h0000_0201);
        exp_period(0, 384, 192, "R2 divide B prescale 32 count 2");

        wr(ADDR_CTRL, 32'h0000_0000);
        exp_period(0, 24, 12, "R7 setup generator A divide 6");
        reconfig_timing();
        wr(ADDR_DIV_A, 32'h0000_0002);
        exp_period(0, 24, 12, "R7 divide restored");

        wr(ADDR_CTRL, 32'h0030_0000);
        repeat (40) @(negedge clk);
        exp_stable(0, "R4 invalid source code 3 holds");
        wr(ADDR_CTRL, 32'h0000_0000);
        exp_period(0, 24, 12, "R4 valid code restarts");

        wr(ADDR_PSEL0, 32'h2010_0302);
        exp_period(4, 6, 3, "R8 code 02 ref B");
        exp_period(5, 10, 5, "R8 code 03 ref C");
        exp_period(6, 24, 12, "R8 code 10 generator A");
        exp_period(7, 256, 128, "R8 code 20 generator B");

        wr(ADDR_PSEL0 + 1, 32'h0355_0100);
        wr(ADDR_PSEL0 + 2, 32'h0000_0201);
        exp_period(8, 8, 4, "R8 code 00 ref I");
        exp_period(9, 4, 2, "R8 code 01 ref A");
        exp_period(11, 10, 5, "R8 port7 ref C");
        exp_period(12, 10, 5, "R9 port8 follows port7");
        exp_period(13, 6, 3, "R9 port9 byte1 ref B");
        exp_low(10, "R10 code 55 low");

        wr(ADDR_PSEL0, 32'h2010_0304);
        exp_low(4, "R10 code 04 low");

        wr(ADDR_PSEL0 + 1, 32'h0155_0100);
        exp_period(12, 4, 2, "R9 port8 tracks port7 change");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule